// File: doc/BRIEF.md
# Backup Supply Switchover Controller

This block chooses the source of the protected RAM supply rail. It selects either the main supply or the backup battery, and it drives one enable for each analog switch. Its inputs are comparator flags that are already synchronized to the clock. They report three things about the main supply: whether it is above the reset threshold, above the battery voltage, and above the lowest level at which switching still works. The block takes the battery path only when the main supply has dropped below both the reset threshold and the battery voltage, or when it has fallen under the minimum switching level. On every change of source it holds both enables low for one cycle.

The block also has a factory isolation mode that keeps a fresh battery from draining during storage. The mode is set by a strap condition: the battery is present, the power-fail output pin is tied to ground, the power-fail input is tied to the main supply, and the main supply is above threshold. The strap must hold for a number of timebase ticks that lies strictly inside a window, and then end. While the isolation mode is active the battery switch stays open. The mode ends at the next reset-release pulse that arrives while the main supply is up. The isolation flag is cleared only by the power-on reset, so it survives a full loss of the main supply.

Top module: `bkp_switch_ctrl`

## Requirements
- R1: With the main supply at or above the minimum switching level and the block not isolated, the battery is selected only when `main_ok_i`=0 and `main_gt_bat_i`=0. Every other combination selects the main supply, so a return from battery happens as soon as either flag goes to 1.
- R2: While `main_ok_i`=1 and `main_min_ok_i`=1, `bat_en_o` is 0, even when the battery is above the main supply (`main_gt_bat_i`=0).
- R3: When `main_min_ok_i`=0, the battery is selected whatever `main_ok_i` and `main_gt_bat_i` say, unless the block is isolated.
- R4: `main_en_o` and `bat_en_o` are never 1 in the same cycle. After an input change that calls for the other source, both enables are 0 after the first clock edge, and the new enable is 1 after the second.
- R5: The strap condition is `bat_present_i`, `pfo_grounded_i`, `pfi_high_i` and `main_ok_i` all at 1. While it holds, `tick_i` pulses are counted. If the strap ends with a count strictly greater than SEAL_MIN_TICKS (5) and strictly less than SEAL_MAX_TICKS (35), `sealed_o` becomes 1 on the clock edge that sees the strap end.
- R6: If the strap ends with a count at or below SEAL_MIN_TICKS, or at or above SEAL_MAX_TICKS, `sealed_o` stays 0. The count restarts from zero on the next strap period and does not add to an earlier one.
- R7: While isolated, `bat_en_o` is 0 and `main_en_o` is 1, including the cycle in which isolation is entered and any time R1 or R3 would select the battery.
- R8: `sealed_o` clears on the clock edge that sees `rst_release_i`=1 together with `main_ok_i`=1. A release pulse while `main_ok_i`=0 has no effect.
- R9: Once set, `sealed_o` stays 1 through loss and return of the main supply until R8 clears it. Only `rst_ni` otherwise resets it.
- R10: During and right after `rst_ni`=0, all three outputs are 0. The first clock edge after reset selects a source from the inputs, with no dead cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Power-on reset, asynchronous, active low |
| tick_i | input | 1 | One-cycle timebase pulse for the strap window |
| main_ok_i | input | 1 | Main supply above the reset threshold |
| main_gt_bat_i | input | 1 | Main supply above the battery voltage |
| main_min_ok_i | input | 1 | Main supply above the minimum switching level |
| bat_present_i | input | 1 | Battery present |
| pfi_high_i | input | 1 | Power-fail input tied to the main supply |
| pfo_grounded_i | input | 1 | Power-fail output pin held to ground externally |
| rst_release_i | input | 1 | Reset-release pulse from the reset generator |
| main_en_o | output | 1 | Close the main supply switch |
| bat_en_o | output | 1 | Close the battery switch |
| sealed_o | output | 1 | Battery isolation mode active |

## Verification
The hardest state to reach from the ports is isolation entry with a visible effect. The strap has to be held while a chosen number of ticks is counted, and it then has to end by removing the main supply, so that the switchover rule would otherwise pick the battery. The stimulus runs that sequence at tick counts of 5, 6, 34 and 35 to cover both edges of the window. It also splits one strap into 3 ticks and 4 ticks to show that counts do not carry over between strap periods. After each isolation, the main supply is restored and a release pulse is sent to clear it. A release sent while the main supply is still absent must leave the flag set.

// File: rtl/bkp_pkg.sv
package bkp_pkg;
  typedef enum logic [1:0] {
    SRC_GAP  = 2'd0,
    SRC_MAIN = 2'd1,
    SRC_BAT  = 2'd2
  } src_e;
endpackage

// File: rtl/bkp_seal_win.sv
module bkp_seal_win #(
  parameter int MIN_TICKS = 5,
  parameter int MAX_TICKS = 35
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strap_i,
  input  logic tick_i,
  output logic hit_o
);
  localparam int CNT_W = $clog2(MAX_TICKS + 1);
  localparam logic [CNT_W-1:0] MIN_C = CNT_W'(MIN_TICKS);
  localparam logic [CNT_W-1:0] MAX_C = CNT_W'(MAX_TICKS);

  logic [CNT_W-1:0] cnt_q;
  logic             strap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      strap_q <= 1'b0;
    end else begin
      strap_q <= strap_i;
      if (!strap_i)                       cnt_q <= '0;
      else if (tick_i && cnt_q != MAX_C)  cnt_q <= cnt_q + 1'b1;
    end
  end

  // strap just ended with a count strictly inside the window
  assign hit_o = strap_q && !strap_i && (cnt_q > MIN_C) && (cnt_q < MAX_C);

  assert_cnt_sat_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= MAX_C);
  assert_cnt_restart_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strap_i |=> cnt_q == '0);
endmodule

// File: rtl/bkp_seal_reg.sv
module bkp_seal_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hit_i,
  input  logic rel_i,
  input  logic main_ok_i,
  output logic sealed_o,
  output logic block_o
);
  logic sealed_q;
  logic clr;

  assign clr = rel_i && main_ok_i;

  // cleared only by power-on reset or a qualified release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    sealed_q <= 1'b0;
    else if (clr)   sealed_q <= 1'b0;
    else if (hit_i) sealed_q <= 1'b1;
  end

  assign sealed_o = sealed_q;
  // block the battery already in the entry cycle
  assign block_o  = sealed_q || (hit_i && !clr);

  assert_clear_src_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sealed_o) |-> $past(rel_i && main_ok_i));
  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sealed_o && !(rel_i && main_ok_i)) |=> sealed_o);
endmodule

// File: rtl/bkp_src_sel.sv
module bkp_src_sel
  import bkp_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic main_ok_i,
  input  logic main_gt_bat_i,
  input  logic main_min_ok_i,
  input  logic block_i,
  output logic main_en_o,
  output logic bat_en_o
);
  src_e state_q, state_d;
  logic want_bat;

  assign want_bat = !block_i && (!main_min_ok_i || (!main_ok_i && !main_gt_bat_i));

  always_comb begin
    case (state_q)
      SRC_MAIN: state_d = want_bat ? SRC_GAP : SRC_MAIN;
      SRC_BAT:  state_d = want_bat ? SRC_BAT : SRC_GAP;
      default:  state_d = want_bat ? SRC_BAT : SRC_MAIN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= SRC_GAP;
    else         state_q <= state_d;
  end

  assign main_en_o = (state_q == SRC_MAIN);
  assign bat_en_o  = (state_q == SRC_BAT);

  assert_excl_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(main_en_o && bat_en_o));
  assert_gap_to_bat_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bat_en_o) |-> $past(!main_en_o));
  assert_gap_to_main_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(main_en_o) |-> $past(!bat_en_o));
  assert_no_bat_above_thr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(main_ok_i && main_min_ok_i) |-> !bat_en_o);
endmodule

// File: rtl/bkp_switch_ctrl.sv
module bkp_switch_ctrl #(
  parameter int SEAL_MIN_TICKS = 5,
  parameter int SEAL_MAX_TICKS = 35
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic main_ok_i,
  input  logic main_gt_bat_i,
  input  logic main_min_ok_i,
  input  logic bat_present_i,
  input  logic pfi_high_i,
  input  logic pfo_grounded_i,
  input  logic rst_release_i,
  output logic main_en_o,
  output logic bat_en_o,
  output logic sealed_o
);
  logic strap;
  logic hit;
  logic block;

  assign strap = bat_present_i && pfo_grounded_i && pfi_high_i && main_ok_i;

  bkp_seal_win #(
    .MIN_TICKS(SEAL_MIN_TICKS),
    .MAX_TICKS(SEAL_MAX_TICKS)
  ) u_win (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .strap_i(strap),
    .tick_i (tick_i),
    .hit_o  (hit)
  );

  bkp_seal_reg u_seal (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .hit_i    (hit),
    .rel_i    (rst_release_i),
    .main_ok_i(main_ok_i),
    .sealed_o (sealed_o),
    .block_o  (block)
  );

  bkp_src_sel u_sel (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .main_ok_i    (main_ok_i),
    .main_gt_bat_i(main_gt_bat_i),
    .main_min_ok_i(main_min_ok_i),
    .block_i      (block),
    .main_en_o    (main_en_o),
    .bat_en_o     (bat_en_o)
  );

  assert_sealed_no_bat_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sealed_o |-> !bat_en_o);
endmodule

// File: tb/bkp_switch_ctrl_test.sv
module bkp_switch_ctrl_test;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic tick_i = 1'b0;
  logic main_ok_i = 1'b1, main_gt_bat_i = 1'b1, main_min_ok_i = 1'b1;
  logic bat_present_i = 1'b0, pfi_high_i = 1'b0, pfo_grounded_i = 1'b0;
  logic rst_release_i = 1'b0;
  logic main_en_o, bat_en_o, sealed_o;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 1'b0;

  typedef struct {
    int    due;
    bit    m;
    bit    b;
    bit    s;
    string req;
  } exp_t;
  exp_t sb[$];

  bkp_switch_ctrl uut (.*);

  always #10 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  // monitor: pop items that fall due in this cycle
  always @(negedge clk_i) begin
    while (sb.size() > 0 && sb[0].due == cyc) begin
      exp_t e;
      e = sb.pop_front();
      total++;
      if ({main_en_o, bat_en_o, sealed_o} !== {e.m, e.b, e.s}) begin
        bad++;
        $display("FAIL %s cyc=%0d actual main=%b bat=%b sealed=%b expected main=%b bat=%b sealed=%b",
                 e.req, cyc, main_en_o, bat_en_o, sealed_o, e.m, e.b, e.s);
      end
    end
  end

  task automatic push(input int dly, input bit m, input bit b, input bit s, input string r);
    exp_t e;
    e.due = cyc + dly; e.m = m; e.b = b; e.s = s; e.req = r;
    sb.push_back(e);
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic set_in(input bit ok, input bit gt, input bit mn,
                        input bit bp, input bit pf, input bit pg);
    main_ok_i = ok; main_gt_bat_i = gt; main_min_ok_i = mn;
    bat_present_i = bp; pfi_high_i = pf; pfo_grounded_i = pg;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick_i = 1'b1; @(negedge clk_i);
      tick_i = 1'b0; @(negedge clk_i);
    end
  endtask

  task automatic release_pulse(input bit exp_sealed, input string r);
    rst_release_i = 1'b1;
    push(1, 1, 0, exp_sealed, r);
    @(negedge clk_i);
    rst_release_i = 1'b0;
    wait_cyc(3);
  endtask

  // strap for n ticks, then remove main power
  task automatic seal_try(input int n, input bit expect_seal, input string r);
    set_in(1, 1, 1, 1, 1, 1);
    wait_cyc(1);
    ticks(n);
    set_in(0, 0, 0, 1, 1, 1);
    if (expect_seal) begin
      push(1, 1, 0, 1, r);
      push(2, 1, 0, 1, "R7");
    end else begin
      push(1, 0, 0, 0, r);
      push(2, 0, 1, 0, r);
    end
    wait_cyc(4);
  endtask

  // bring main back and clear any seal
  task automatic restore(input bit was_sealed);
    set_in(1, 1, 1, 0, 0, 0);
    if (was_sealed) begin
      push(2, 1, 0, 1, "R9");
      wait_cyc(3);
      release_pulse(0, "R8");
    end else begin
      push(1, 0, 0, 0, "R4");
      push(2, 1, 0, 0, "R1");
      wait_cyc(4);
    end
  endtask

  initial begin
    wait_cyc(3);
    total++;
    if ({main_en_o, bat_en_o, sealed_o} !== 3'b000) begin
      bad++;
      $display("FAIL R10 actual %b%b%b expected 000", main_en_o, bat_en_o, sealed_o);
    end
    rst_ni = 1'b1;
    push(1, 1, 0, 0, "R10");
    wait_cyc(3);

    // battery above main, main above threshold: stay on main
    set_in(1, 0, 1, 0, 0, 0);
    push(1, 1, 0, 0, "R2"); push(2, 1, 0, 0, "R2");
    wait_cyc(4);
    // both below: battery, with dead cycle
    set_in(0, 0, 1, 0, 0, 0);
    push(1, 0, 0, 0, "R4"); push(2, 0, 1, 0, "R1");
    wait_cyc(4);
    // main rises above battery only: return to main
    set_in(0, 1, 1, 0, 0, 0);
    push(1, 0, 0, 0, "R4"); push(2, 1, 0, 0, "R1");
    wait_cyc(4);
    set_in(0, 0, 1, 0, 0, 0);
    push(2, 0, 1, 0, "R1");
    wait_cyc(4);
    // main rises above threshold only: return to main
    set_in(1, 0, 1, 0, 0, 0);
    push(1, 0, 0, 0, "R4"); push(2, 1, 0, 0, "R1");
    wait_cyc(4);
    // below minimum level: battery despite comparison
    set_in(0, 1, 0, 0, 0, 0);
    push(1, 0, 0, 0, "R4"); push(2, 0, 1, 0, "R3");
    wait_cyc(4);
    restore(0);

    // window edges
    seal_try(5, 0, "R6");
    restore(0);
    seal_try(6, 1, "R5");
    push(8, 1, 0, 1, "R9");
    wait_cyc(10);
    release_pulse(1, "R8");
    restore(1);
    seal_try(34, 1, "R5");
    restore(1);
    seal_try(35, 0, "R6");
    restore(0);

    // count restarts between strap periods: 3 + 4 must not seal
    set_in(1, 1, 1, 1, 1, 1);
    wait_cyc(1);
    ticks(3);
    set_in(1, 1, 1, 1, 1, 0);
    push(2, 1, 0, 0, "R6");
    wait_cyc(3);
    seal_try(4, 0, "R6");
    restore(0);

    wait_cyc(3);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule